// File: doc/BRIEF.md
# Open-Drain Line Direction Bridge

This block joins two open-drain serial data lines, one facing a host controller and one facing a card, each held high by a resistor when nobody drives it. While both lines rest high the bridge drives nothing. The first side whose level falls is taken as the master for the transfer. After a fixed count of clock cycles, its low level is reproduced on the opposite side through that side's pull-down enable. Falling-edge sensing on the opposite side is switched off until the transfer completes, so the copied low cannot turn around and claim the bus.

When the master lets its line rise, the bridge stops pulling the other side down. One clock cycle later it drives that side actively high for a fixed number of cycles, which gives the line a fast rising edge. Both sides then return to rest, and either side can win the next falling edge. Each line is sampled through a two-flop synchronizer. The control state is exposed as a two-bit code.

Top module: `io_line_bridge`

## Requirements
- R1: While reset is asserted, and from its release until a falling edge is seen, all four drive enables are 0 and `xfer_state_o` reads 0 (idle). Asserting reset in the middle of a transfer clears the drive enables and the state at once, without waiting for a clock edge.
- R2: When only the host line falls, `xfer_state_o` becomes 1 (host is master) on the third rising clock edge after the fall, and stays 0 before that edge.
- R3: When only the card line falls, `xfer_state_o` becomes 2 (card is master) on the third rising edge after the fall.
- R4: When both lines fall before the same clock edge, the card side becomes master (`xfer_state_o` = 2).
- R5: While a transfer is in progress, a low level or falling edge on the slave line does not change the master selection.
- R6: The slave side's pull-down enable rises on rising edge number `TD_CYC`+1, counted from the edge that enters the master state, provided the master line is still low. It is 0 before that edge.
- R7: After the master line rises, the slave pull-down enable drops on the third rising edge, and `xfer_state_o` reads 3 (pull-up phase) from that same edge. The slave pull-up enable rises one edge later, so the two are never active together.
- R8: The slave pull-up enable stays high for exactly `TW_CYC` cycles. On the edge where it drops, `xfer_state_o` returns to 0 and all drive enables are 0.
- R9: If the master line rises before the forwarding delay has run out, the slave side is never pulled down, but the gap cycle and the pull-up pulse still take place.
- R10: The master side's pull-down and pull-up enables stay 0 for the whole transfer. At most one of the four drive enables is active in any cycle.
- R11: Once the bridge is back in idle, the side that was slave in the previous transfer can become master in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_line_i | input | 1 | Sampled level of the host-side line |
| card_line_i | input | 1 | Sampled level of the card-side line |
| host_pd_o | output | 1 | Pull-down enable for the host-side line |
| host_pu_o | output | 1 | Active pull-up enable for the host-side line |
| card_pd_o | output | 1 | Pull-down enable for the card-side line |
| card_pu_o | output | 1 | Active pull-up enable for the card-side line |
| xfer_state_o | output | 2 | 0 idle, 1 host master, 2 card master, 3 pull-up phase |

## Verification
Some properties are checked on every cycle. These are: the one-hot limit on the drive enables, the quiet master side, the one-cycle gap between a falling pull-down and the rising pull-up, the card priority on a tie, the lock of the master while its line stays low, and the return to idle as the pulse ends. The exact cycle counts from a fall to the master state, from the master state to the forwarded low, and from the release to the pulse can only be shown by the bench's scenarios. The same holds for the pulse width, the early-release case and the handover of mastership between transfers.

// File: rtl/iob_pkg.sv
package iob_pkg;

  // line vector bit positions
  localparam int unsigned SIDE_HOST = 0;
  localparam int unsigned SIDE_CARD = 1;

  // internal controller states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOST  = 3'd1,
    ST_CARD  = 3'd2,
    ST_GAP   = 3'd3,
    ST_PULSE = 3'd4
  } ctrl_st_e;

  // externally visible transfer code
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_HOST   = 2'd1,
    XS_CARD   = 2'd2,
    XS_PULLUP = 2'd3
  } xfer_st_e;

endpackage

// File: rtl/iob_sync.sv
module iob_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= RST_VAL;
      end
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/iob_fall_det.sv
module iob_fall_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] arm_i,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign fall_o[i] = prev_q[i] & ~lvl_i[i] & arm_i[i];
    end
  endgenerate

  // R5: a lane cannot report a fall on two consecutive cycles
  no_double_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_o) |=> ((fall_o & $past(fall_o)) == '0));

endmodule

// File: rtl/iob_timer.sv
module iob_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R6: the controller never decrements an expired count
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/iob_ctrl.sv
module iob_ctrl
  import iob_pkg::*;
#(
  parameter int TD_CYC = 8,
  parameter int TW_CYC = 4,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lvl_i,
  input  logic [1:0]    fall_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          tmr_dec_o,
  output logic [1:0]    arm_o,
  output logic [1:0]    pd_o,
  output logic [1:0]    pu_o,
  output logic [1:0]    xfer_st_o
);

  localparam logic [CW-1:0] TD_LD = CW'(TD_CYC);
  localparam logic [CW-1:0] TW_LD = CW'(TW_CYC - 1);

  ctrl_st_e st_q, st_d;
  logic     fwd_q, fwd_d;
  logic     cmst_q, cmst_d;
  logic     mst_hi;

  assign mst_hi = cmst_q ? lvl_i[SIDE_CARD] : lvl_i[SIDE_HOST];

  always_comb begin
    st_d       = st_q;
    fwd_d      = fwd_q;
    cmst_d     = cmst_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = TD_LD;
    tmr_dec_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall_i[SIDE_CARD]) begin
          st_d       = ST_CARD;
          cmst_d     = 1'b1;
          fwd_d      = 1'b0;
          tmr_load_o = 1'b1;
        end else if (fall_i[SIDE_HOST]) begin
          st_d       = ST_HOST;
          cmst_d     = 1'b0;
          fwd_d      = 1'b0;
          tmr_load_o = 1'b1;
        end
      end
      ST_HOST, ST_CARD: begin
        if (mst_hi) begin
          st_d  = ST_GAP;
          fwd_d = 1'b0;
        end else if (!tmr_zero_i) begin
          tmr_dec_o = 1'b1;
        end else begin
          fwd_d = 1'b1;
        end
      end
      ST_GAP: begin
        st_d       = ST_PULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW_LD;
      end
      ST_PULSE: begin
        if (tmr_zero_i) st_d = ST_IDLE;
        else            tmr_dec_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fwd_q  <= 1'b0;
      cmst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fwd_q  <= fwd_d;
      cmst_q <= cmst_d;
    end
  end

  // edge sensing only while no transfer owns the lines
  assign arm_o[SIDE_HOST] = (st_q == ST_IDLE);
  assign arm_o[SIDE_CARD] = (st_q == ST_IDLE);

  assign pd_o[SIDE_HOST] = (st_q == ST_CARD) & fwd_q;
  assign pd_o[SIDE_CARD] = (st_q == ST_HOST) & fwd_q;
  assign pu_o[SIDE_HOST] = (st_q == ST_PULSE) &  cmst_q;
  assign pu_o[SIDE_CARD] = (st_q == ST_PULSE) & ~cmst_q;

  always_comb begin
    unique case (st_q)
      ST_IDLE:           xfer_st_o = XS_IDLE;
      ST_HOST:           xfer_st_o = XS_HOST;
      ST_CARD:           xfer_st_o = XS_CARD;
      ST_GAP, ST_PULSE:  xfer_st_o = XS_PULLUP;
      default:           xfer_st_o = XS_IDLE;
    endcase
  end

  // R4
  tie_card_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && fall_i[SIDE_HOST] && fall_i[SIDE_CARD]) |=> (st_q == ST_CARD));

  // R5
  host_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOST && !lvl_i[SIDE_HOST]) |=> (st_q == ST_HOST));

  // R5
  card_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CARD && !lvl_i[SIDE_CARD]) |=> (st_q == ST_CARD));

  // R7
  card_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_o[SIDE_CARD]) |-> !pu_o[SIDE_CARD]);

  // R7
  card_pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_o[SIDE_CARD]) |=> pu_o[SIDE_CARD]);

  // R7
  host_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_o[SIDE_HOST]) |-> !pu_o[SIDE_HOST]);

  // R7
  host_pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_o[SIDE_HOST]) |=> pu_o[SIDE_HOST]);

endmodule

// File: rtl/io_line_bridge.sv
module io_line_bridge
  import iob_pkg::*;
#(
  parameter int TD_CYC      = 8,
  parameter int TW_CYC      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_line_i,
  input  logic       card_line_i,
  output logic       host_pd_o,
  output logic       host_pu_o,
  output logic       card_pd_o,
  output logic       card_pu_o,
  output logic [1:0] xfer_state_o
);

  localparam int CNT_MAX = (TD_CYC > TW_CYC) ? TD_CYC : TW_CYC;
  localparam int CW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  logic          rst_ok_n;
  logic [1:0]    line_raw, line_s, fall, arm, pd, pu;
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [CW-1:0] tmr_val;

  // asynchronous assertion, synchronous release
  iob_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_ok_n)
  );

  assign line_raw[SIDE_HOST] = host_line_i;
  assign line_raw[SIDE_CARD] = card_line_i;

  iob_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_ok_n),
    .d_i   (line_raw),
    .q_o   (line_s)
  );

  iob_fall_det #(.WIDTH(2)) u_fall (
    .clk    (clk),
    .rst_n  (rst_ok_n),
    .lvl_i  (line_s),
    .arm_i  (arm),
    .fall_o (fall)
  );

  iob_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_ok_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  iob_ctrl #(.TD_CYC(TD_CYC), .TW_CYC(TW_CYC), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ok_n),
    .lvl_i      (line_s),
    .fall_i     (fall),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_dec_o  (tmr_dec),
    .arm_o      (arm),
    .pd_o       (pd),
    .pu_o       (pu),
    .xfer_st_o  (xfer_state_o)
  );

  assign host_pd_o = pd[SIDE_HOST];
  assign card_pd_o = pd[SIDE_CARD];
  assign host_pu_o = pu[SIDE_HOST];
  assign card_pu_o = pu[SIDE_CARD];

  // R10
  one_drive_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0({host_pd_o, host_pu_o, card_pd_o, card_pu_o}));

  // R10
  host_master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (xfer_state_o == XS_HOST) |-> (!host_pd_o && !host_pu_o));

  // R10
  card_master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (xfer_state_o == XS_CARD) |-> (!card_pd_o && !card_pu_o));

  // R8
  pulse_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ($fell(host_pu_o) || $fell(card_pu_o)) |-> (xfer_state_o == XS_IDLE));

endmodule

// File: tb/io_line_bridge_test.sv
module io_line_bridge_test;

  localparam int TD = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic card_low = 1'b0;
  logic host_pd_o, host_pu_o, card_pd_o, card_pu_o;
  logic [1:0] xfer_state_o;
  logic host_line, card_line;
  logic done = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  // open-drain wiring: either party may pull the line low
  assign host_line = ~(host_low | host_pd_o);
  assign card_line = ~(card_low | card_pd_o);

  io_line_bridge #(.TD_CYC(TD), .TW_CYC(TW), .SYNC_STAGES(2)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_line_i  (host_line),
    .card_line_i  (card_line),
    .host_pd_o    (host_pd_o),
    .host_pu_o    (host_pu_o),
    .card_pd_o    (card_pd_o),
    .card_pu_o    (card_pu_o),
    .xfer_state_o (xfer_state_o)
  );

  // {host drives low, card drives low, expected master code}
  localparam logic [3:0] VEC [4] = '{
    {1'b1, 1'b0, 2'd1},   // R2 host alone
    {1'b0, 1'b1, 2'd2},   // R3 card alone, R11 previous slave wins
    {1'b1, 1'b1, 2'd2},   // R4 tie, card priority
    {1'b1, 1'b0, 2'd1}    // R11 host again after card transfers
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic slave_pd(input logic card_slave);
    return card_slave ? card_pd_o : host_pd_o;
  endfunction

  function automatic logic slave_pu(input logic card_slave);
    return card_slave ? card_pu_o : host_pu_o;
  endfunction

  function automatic int drives();
    return int'({host_pd_o, host_pu_o, card_pd_o, card_pu_o});
  endfunction

  task automatic start_xfer(input logic dh, input logic dc, input logic [1:0] est, input string req);
    @(negedge clk);
    host_low = dh;
    card_low = dc;
    @(negedge clk);
    @(negedge clk);
    chk({req, " still idle"}, int'(xfer_state_o), 0);
    @(negedge clk);
    chk({req, " master code"}, int'(xfer_state_o), int'(est));
  endtask

  task automatic release_and_pulse(input logic card_slave, input logic pd_on);
    int cnt;
    host_low = 1'b0;
    card_low = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 pd held before release seen", int'(slave_pd(card_slave)), int'(pd_on));
    @(negedge clk);
    chk("R7 pd dropped", int'(slave_pd(card_slave)), 0);
    chk("R7 gap has no pull-up", int'(slave_pu(card_slave)), 0);
    chk("R7 state pull-up code", int'(xfer_state_o), 3);
    @(negedge clk);
    cnt = 0;
    while (slave_pu(card_slave) && cnt < 2 * TW) begin
      cnt++;
      @(negedge clk);
    end
    chk("R8 pulse width", cnt, TW);
    chk("R8 back to idle", int'(xfer_state_o), 0);
    chk("R8 drives off", drives(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 state in reset", int'(xfer_state_o), 0);
    chk("R1 drives in reset", drives(), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 state after reset", int'(xfer_state_o), 0);
    chk("R1 drives after reset", drives(), 0);

    // table-driven full transfers
    for (int i = 0; i < 4; i++) begin
      logic cs;
      cs = (VEC[i][1:0] == 2'd1);
      start_xfer(VEC[i][3], VEC[i][2], VEC[i][1:0],
                 (i == 0) ? "R2" : (i == 2) ? "R4" : "R3/R11");
      repeat (TD) @(negedge clk);
      chk("R6 slave pd not yet", int'(slave_pd(cs)), 0);
      @(negedge clk);
      chk("R6 slave pd forwarded", int'(slave_pd(cs)), 1);
      chk("R10 master side quiet",
          int'(cs ? (host_pd_o | host_pu_o) : (card_pd_o | card_pu_o)), 0);
      release_and_pulse(cs, 1'b1);
      repeat (3) @(negedge clk);
    end

    // R9 early release
    start_xfer(1'b1, 1'b0, 2'd1, "R2 early");
    repeat (2) @(negedge clk);
    chk("R9 no pd before delay", int'(card_pd_o), 0);
    release_and_pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);

    // R5 slave activity ignored
    start_xfer(1'b1, 1'b0, 2'd1, "R2 lock");
    card_low = 1'b1;
    repeat (3) @(negedge clk);
    card_low = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 master kept", int'(xfer_state_o), 1);
    repeat (TD - 4) @(negedge clk);
    chk("R5 card pd after slave glitch", int'(card_pd_o), 1);
    card_low = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 master kept under slave low", int'(xfer_state_o), 1);
    card_low = 1'b0;
    release_and_pulse(1'b1, 1'b1);
    repeat (3) @(negedge clk);

    // R1 reset in mid transfer
    start_xfer(1'b0, 1'b1, 2'd2, "R3 reset");
    repeat (TD + 1) @(negedge clk);
    chk("R6 host pd before reset", int'(host_pd_o), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear drives", drives(), 0);
    chk("R1 async clear state", int'(xfer_state_o), 0);
    card_low = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle after mid reset", int'(xfer_state_o), 0);
    chk("R1 drives after mid reset", drives(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule